// File: doc/BRIEF.md
# Dual-Threshold Time-Over-Threshold Event Recorder

This block is the digital back end of one multi-channel strip readout chip. Every channel delivers two comparator bits. The low comparator sets the readout threshold and the high comparator sets the hit threshold. The block samples both bits on a coarse timebase of eight fast clock cycles, which is 400 ns at a 50 ns fast clock. It stamps every accepted on or off transition with a 13-bit wrapping timebase count and stores it as a record in a FIFO. Pulse height is later recovered off chip from the leading and trailing times, so no analog sample is buffered.

A high-comparator turn-on counts as a hit only inside the window opened by the low comparator. The matching turn-off of the high comparator is reported only for a hit that was accepted. The low comparator's own edges are always reported, because they bound the window.

An 8:1 output multiplexer running on the fast clock sends one FIFO record per timebase period. Each record is split into eight lanes of LANE_W bits. A frame marker flags the first slot of each frame. A sticky flag reports that records were lost.

Top module: `tot_event_recorder`

## Requirements
- R1: A frame is 8 fast cycles. `sof_o` is high in slot 0 only. The timestamp starts at 0 in the first frame after reset, advances by one per frame and wraps from 8191 to 0.
- R2: A record is {channel, lead, high, timestamp} with the timestamp in bits [12:0], high in bit 13 (1 = high comparator), lead in bit 14 (1 = turn-on) and the channel above. An output frame word carries the record in its low bits and a valid bit directly above it, and lane k of the word is sent in slot k.
- R3: Every turn-on and turn-off of a low comparator produces a record.
- R4: A high-comparator turn-on produces a record only if that channel's low comparator is on in the same sample. A high turn-off produces a record only if the preceding turn-on was accepted. All other high transitions produce nothing.
- R5: Records from one sample enter the FIFO one per fast cycle, in ascending channel order, with the low comparator before the high comparator within a channel.
- R6: A comparator level applied in slot 0 of frame f is stamped f. Its record is the first one sent when the FIFO was empty, and it appears in output frame f+2.
- R7: At most 8 records are taken per sample. Any further records from that sample are dropped and set `lost_o`. Exactly 8 records lose nothing.
- R8: A record that finds the FIFO full is dropped and sets `lost_o`. Records already stored are sent intact, and `lost_o` stays set until reset.
- R9: When the FIFO is empty at frame load, the whole frame is zero, which includes a cleared valid bit.
- R10: During reset `lost_o` is 0, the output lanes are 0, and no comparator state from before reset produces records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock (50 ns), one output slot per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmp_lo_i | input | N_CH | Low (readout) comparator per channel, asynchronous |
| cmp_hi_i | input | N_CH | High (hit) comparator per channel, asynchronous |
| ser_data_o | output | LANE_W | Output lane of the current slot |
| sof_o | output | 1 | High in slot 0 of each output frame |
| lost_o | output | 1 | Sticky flag: records were dropped |

## Verification
The assertions check the framing and timestamp step, the stickiness of the loss flag, the loss flag following any write into a full FIFO, and the zero frame that follows an empty FIFO, on every cycle. The window rule for high-comparator edges, the ascending scan order, the timestamp carried by each record, the two-frame latency and the exact set of records that survive a scan backlog or a full FIFO are shown only by the bench's scenarios, which decode the output lanes.

// File: rtl/tot_pkg.sv
package tot_pkg;
  localparam int TS_W   = 13;
  localparam int SLOTS  = 8;
  localparam int SLOT_W = $clog2(SLOTS);
  typedef logic [TS_W-1:0] ts_t;
endpackage

// File: rtl/tot_capture.sv
module tot_capture #(
  parameter int N_CH = 8,
  localparam int N_EV = 2 * N_CH
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [N_CH-1:0] lo_i,
  input  logic [N_CH-1:0] hi_i,
  output logic [N_EV-1:0] ev_o,
  output logic [N_EV-1:0] lvl_o
);
  logic [N_CH-1:0] lo_s1, lo_s2, hi_s1, hi_s2;
  logic [N_CH-1:0] lo_q, hi_q, armed_q, armed_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_s1 <= '0; lo_s2 <= '0; hi_s1 <= '0; hi_s2 <= '0;
      lo_q <= '0; hi_q <= '0; armed_q <= '0;
    end else begin
      lo_s1 <= lo_i; lo_s2 <= lo_s1;
      hi_s1 <= hi_i; hi_s2 <= hi_s1;
      if (tick_i) begin
        lo_q    <= lo_s2;
        hi_q    <= hi_s2;
        armed_q <= armed_d;
      end
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic hi_rise, hi_fall, acc_rise, acc_fall;
    assign hi_rise  = hi_s2[c] & ~hi_q[c];
    assign hi_fall  = ~hi_s2[c] & hi_q[c];
    // hit only inside the low-comparator window
    assign acc_rise = hi_rise & lo_s2[c];
    assign acc_fall = hi_fall & armed_q[c];
    assign armed_d[c]    = acc_rise | (armed_q[c] & ~hi_fall);
    assign ev_o[2*c]     = lo_s2[c] ^ lo_q[c];
    assign ev_o[2*c+1]   = acc_rise | acc_fall;
    assign lvl_o[2*c]    = lo_s2[c];
    assign lvl_o[2*c+1]  = hi_s2[c];
  end
endmodule

// File: rtl/tot_scan.sv
module tot_scan #(
  parameter int N_CH = 8,
  parameter int TS_W = 13,
  localparam int N_EV  = 2 * N_CH,
  localparam int IDX_W = $clog2(N_EV),
  localparam int REC_W = IDX_W + 1 + TS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [N_EV-1:0]  ev_i,
  input  logic [N_EV-1:0]  lvl_i,
  input  logic [TS_W-1:0]  ts_i,
  output logic             wr_o,
  output logic [REC_W-1:0] rec_o,
  output logic             drop_o
);
  logic [N_EV-1:0]  pend_q, lvl_q, rest;
  logic [TS_W-1:0]  ts_q;
  logic [IDX_W-1:0] idx;

  always_comb begin
    idx = '0;
    for (int i = N_EV - 1; i >= 0; i--)
      if (pend_q[i]) idx = IDX_W'(i);
  end

  assign rest   = pend_q & (pend_q - 1'b1);
  assign wr_o   = |pend_q;
  assign drop_o = tick_i & (|rest);
  assign rec_o  = {idx[IDX_W-1:1], lvl_q[idx], idx[0], ts_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0; lvl_q <= '0; ts_q <= '0;
    end else if (tick_i) begin
      pend_q <= ev_i;
      lvl_q  <= lvl_i;
      ts_q   <= ts_i;
    end else begin
      pend_q <= rest;
    end
  end
endmodule

// File: rtl/tot_fifo.sv
module tot_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] din_i,
  input  logic         rd_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic push, pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign push    = wr_i & ~full_o;
  assign pop     = rd_i & ~empty_o;
  assign dout_o  = mem[rp_q];

  always_ff @(posedge clk_i) if (push) mem[wp_q] <= din_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (push) wp_q <= (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (pop)  rp_q <= (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/tot_ser.sv
module tot_ser #(
  parameter int REC_W  = 18,
  parameter int LANE_W = 3,
  parameter int SLOTS  = 8,
  localparam int SLOT_W  = $clog2(SLOTS),
  localparam int FRAME_W = LANE_W * SLOTS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              have_i,
  input  logic [REC_W-1:0]  rec_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [LANE_W-1:0] data_o
);
  logic [FRAME_W-1:0] frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     frame_q <= '0;
    else if (load_i) frame_q <= have_i ? FRAME_W'({1'b1, rec_i}) : '0;
  end

  // 8:1 lane multiplexer
  assign data_o = frame_q[slot_i*LANE_W +: LANE_W];
endmodule

// File: rtl/tot_event_recorder.sv
module tot_event_recorder
  import tot_pkg::*;
#(
  parameter int N_CH       = 8,
  parameter int FIFO_DEPTH = 16,
  localparam int N_EV   = 2 * N_CH,
  localparam int REC_W  = $clog2(N_EV) + 1 + TS_W,
  localparam int LANE_W = (REC_W + 1 + SLOTS - 1) / SLOTS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   cmp_lo_i,
  input  logic [N_CH-1:0]   cmp_hi_i,
  output logic [LANE_W-1:0] ser_data_o,
  output logic              sof_o,
  output logic              lost_o
);
  logic [SLOT_W-1:0] slot_q;
  ts_t               ts_q;
  logic              tick, lost_q;
  logic [N_EV-1:0]   ev, lvl;
  logic              scan_wr, scan_drop, fifo_full, fifo_empty;
  logic [REC_W-1:0]  scan_rec, fifo_rec;

  assign tick  = (slot_q == SLOT_W'(SLOTS - 1));
  assign sof_o = (slot_q == '0);
  assign lost_o = lost_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0; ts_q <= '0; lost_q <= 1'b0;
    end else begin
      slot_q <= tick ? '0 : slot_q + 1'b1;
      if (tick) ts_q <= ts_q + 1'b1;
      if (scan_drop || (scan_wr && fifo_full)) lost_q <= 1'b1;
    end
  end

  tot_capture #(.N_CH(N_CH)) u_cap (
    .clk_i, .rst_ni, .tick_i(tick), .lo_i(cmp_lo_i), .hi_i(cmp_hi_i),
    .ev_o(ev), .lvl_o(lvl));

  tot_scan #(.N_CH(N_CH), .TS_W(TS_W)) u_scan (
    .clk_i, .rst_ni, .tick_i(tick), .ev_i(ev), .lvl_i(lvl), .ts_i(ts_q),
    .wr_o(scan_wr), .rec_o(scan_rec), .drop_o(scan_drop));

  tot_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .wr_i(scan_wr), .din_i(scan_rec), .rd_i(tick),
    .dout_o(fifo_rec), .empty_o(fifo_empty), .full_o(fifo_full));

  tot_ser #(.REC_W(REC_W), .LANE_W(LANE_W), .SLOTS(SLOTS)) u_ser (
    .clk_i, .rst_ni, .load_i(tick), .have_i(~fifo_empty), .rec_i(fifo_rec),
    .slot_i(slot_q), .data_o(ser_data_o));
endmodule

// File: rtl/tot_event_recorder_chk.sv
module tot_event_recorder_chk #(
  parameter int LANE_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              sof_i,
  input logic              lost_i,
  input tot_pkg::ts_t      ts_i,
  input logic              wr_i,
  input logic              full_i,
  input logic              empty_i,
  input logic [LANE_W-1:0] data_i
);
  // R1
  sof_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> !sof_i);
  // R1
  frame_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> sof_i);
  // R1
  ts_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> ts_i == $past(ts_i) + 1'b1);
  // R8
  lost_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_i |=> lost_i);
  // R8
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full_i) |=> lost_i);
  // R9
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && empty_i) |=> data_i == '0);
endmodule

bind tot_event_recorder tot_event_recorder_chk #(.LANE_W(LANE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .sof_i(sof_o),
  .lost_i(lost_o), .ts_i(ts_q), .wr_i(scan_wr), .full_i(fifo_full),
  .empty_i(fifo_empty), .data_i(ser_data_o));

// File: tb/tot_event_recorder_tb.sv
`timescale 1ns/1ps
module tot_event_recorder_tb_top;
  localparam int CLK_PERIOD = 50;
  localparam int N_CH = 8;
  localparam int REC_W = 18;
  localparam int LANE_W = 3;
  localparam int FRAME_W = 24;

  // stimulus {hi[7:0], lo[7:0]}, one per frame
  localparam logic [15:0] STIM [8] = '{
    16'h0001, 16'h0101, 16'h0100, 16'h0000,
    16'h0200, 16'h0000, 16'h0F0F, 16'h0000};
  // expected {vector[2:0], ch[2:0], lead, high}
  localparam logic [7:0] EXP [20] = '{
    8'h02, 8'h23, 8'h40, 8'h61,
    8'hC2, 8'hC3, 8'hC6, 8'hC7, 8'hCA, 8'hCB, 8'hCE, 8'hCF,
    8'hE0, 8'hE1, 8'hE4, 8'hE5, 8'hE8, 8'hE9, 8'hEC, 8'hED};

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [N_CH-1:0] cmp_lo = '0, cmp_hi = '0;
  logic [LANE_W-1:0] ser_data;
  logic sof, lost;

  int n_chk = 0, n_bad = 0;
  int fidx = -1, slot_m = 0, rx_n = 0, idle_bad = 0;
  logic [FRAME_W-1:0] fbuf;
  logic [REC_W-1:0] rx_rec [64];
  int rx_frm [64];
  int fv [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  tot_event_recorder #(.N_CH(N_CH), .FIFO_DEPTH(16)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cmp_lo_i(cmp_lo), .cmp_hi_i(cmp_hi),
    .ser_data_o(ser_data), .sof_o(sof), .lost_o(lost));

  // frame receiver
  always @(negedge clk) begin
    if (!rst_ni) begin
      fidx = -1; slot_m = 0;
    end else begin
      if (sof) begin fidx++; slot_m = 0; fbuf = '0; end
      else slot_m++;
      fbuf[slot_m*LANE_W +: LANE_W] = ser_data;
      if (slot_m == 7) begin
        if (fbuf[REC_W]) begin
          if (rx_n < 64) begin rx_rec[rx_n] = fbuf[REC_W-1:0]; rx_frm[rx_n] = fidx; end
          rx_n++;
        end else if (fbuf != '0) idle_bad++;
      end
    end
  end

  function automatic logic [REC_W-1:0] mk(int ch, bit lead, bit hi, int ts);
    return {3'(ch), lead, hi, 13'(ts)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    cmp_lo = '0; cmp_hi = '0;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 lost_o in reset", 32'(lost), 0);
    chk("R10 lanes in reset", 32'(ser_data), 0);
    rx_n = 0; idle_bad = 0;
    @(posedge clk); #1 rst_ni = 1'b1;
  endtask

  task automatic apply_next(input logic [15:0] pat, output int f);
    forever begin
      @(negedge clk); #1;
      if (sof) break;
    end
    cmp_lo = pat[7:0]; cmp_hi = pat[15:8]; f = fidx;
  endtask

  task automatic apply_at(input int target, input logic [15:0] pat);
    forever begin
      @(negedge clk); #1;
      if (sof && fidx == target) break;
    end
    cmp_lo = pat[7:0]; cmp_hi = pat[15:8];
  endtask

  task automatic wait_frames(input int n);
    repeat (n * 8) @(negedge clk);
    #1;
  endtask

  task automatic run_tests();
    int f, f0, f3;
    // reset and idle
    do_reset();
    wait_frames(4);
    chk("R9 idle frames zero", 32'(idle_bad), 0);
    chk("R10 no records after reset", 32'(rx_n), 0);

    // table of vectors, one per frame
    for (int v = 0; v < 8; v++) begin
      apply_next(STIM[v], f);
      fv[v] = f;
    end
    wait_frames(24);
    chk("R3 R4 record count", 32'(rx_n), 20);
    for (int e = 0; e < 20; e++)
      chk($sformatf("R2 R3 R4 R5 table record %0d", e), 32'(rx_rec[e]),
          32'(mk(int'(EXP[e][4:2]), EXP[e][1], EXP[e][0], fv[EXP[e][7:5]])));
    chk("R6 latency first record frame", 32'(rx_frm[0]), 32'(fv[0] + 2));
    chk("R7 no loss in table", 32'(lost), 0);
    chk("R9 idle frames zero after table", 32'(idle_bad), 0);

    // scan capacity boundary and backlog
    do_reset();
    wait_frames(2);
    apply_next(16'h00FF, f);
    wait_frames(12);
    chk("R7 exactly 8 records kept", 32'(rx_n), 8);
    for (int k = 0; k < 8; k++)
      chk($sformatf("R3 R5 low lead ch %0d", k), 32'(rx_rec[k]), 32'(mk(k, 1, 0, f)));
    chk("R7 no loss at 8 records", 32'(lost), 0);
    apply_next(16'h0000, f);
    wait_frames(12);
    apply_next(16'hFFFF, f3);
    wait_frames(14);
    chk("R7 backlog record count", 32'(rx_n), 24);
    for (int k = 0; k < 8; k++)
      chk($sformatf("R3 low trail ch %0d", k), 32'(rx_rec[8+k]), 32'(mk(k, 0, 0, f)));
    for (int k = 0; k < 8; k++)
      chk($sformatf("R5 R7 backlog kept %0d", k), 32'(rx_rec[16+k]),
          32'(mk(k / 2, 1, k % 2 == 1, f3)));
    chk("R7 backlog sets lost_o", 32'(lost), 1);

    // FIFO overflow
    do_reset();
    wait_frames(2);
    apply_next(16'h00FF, f0);
    apply_next(16'h0000, f);
    apply_next(16'h00FF, f);
    apply_next(16'h0000, f);
    wait_frames(40);
    for (int k = 0; k < 8; k++) begin
      chk($sformatf("R8 stored lead ch %0d", k), 32'(rx_rec[k]), 32'(mk(k, 1, 0, f0)));
      chk($sformatf("R8 stored trail ch %0d", k), 32'(rx_rec[8+k]), 32'(mk(k, 0, 0, f0 + 1)));
    end
    chk("R8 first of third burst kept", 32'(rx_rec[16]), 32'(mk(0, 1, 0, f0 + 2)));
    chk("R8 lost_o set", 32'(lost), 1);
    wait_frames(4);
    chk("R8 lost_o sticky", 32'(lost), 1);

    // timestamp wrap
    do_reset();
    apply_at(8191, 16'h0001);
    apply_next(16'h0000, f);
    wait_frames(6);
    chk("R1 record count at wrap", 32'(rx_n), 2);
    chk("R1 timestamp 8191", 32'(rx_rec[0]), 32'(mk(0, 1, 0, 8191)));
    chk("R1 timestamp wraps to 0", 32'(rx_rec[1]), 32'(mk(0, 0, 0, 0)));
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule